// File: doc/BRIEF.md
# Multi-Channel Compare Timer

A register-mapped timer bank with six independent 32-bit up-counters. Each channel has a compare value. It runs in one of three modes. In one-shot mode it stops at the compare value. In auto-repeat mode it restarts from zero each time it reaches the compare value. In free-run mode it wraps at 2^32. A channel advances on pulses from one of two tick-enable inputs: a fast system tick or a slow reference tick. A divide-by-two option halves the rate.

A compare hit in one-shot or repeat mode sets that channel's bit in a shared pending register. Software clears pending bits by writing ones. A shared enable register masks which pending bits drive the single interrupt line. Software drives the block through a plain synchronous bus with address, write strobe, write data and combinational read data. Reads have no side effects.

Top module: `cmp_timer_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Channel n (1..6) places control, clock, counter and compare at byte offsets 0x10·n + 0x0, 0x4, 0x8 and 0xC. Interrupt enable sits at 0x00 and pending/acknowledge at 0x08, and channel n owns bit n−1 of both. Unmapped offsets read zero.
- R3: Control bit 0 enables the channel. An enabled channel adds one per qualifying tick. A disabled channel holds its count.
- R4: Writing control with bit 1 set zeroes the counter at that write edge. Bit 1 always reads back zero. Setting enable in the same write makes counting start from zero.
- R5: With control bits 5:4 = 1 (repeat), a tick that would bring the count to the compare value loads zero instead and sets the pending bit. The period is therefore the compare value in ticks.
- R6: With control bits 5:4 = 0 (one-shot), the counter stops at the compare value, clears its own enable bit and sets the pending bit.
- R7: With control bits 5:4 = 3 (free-run), and also with the unused code 2, the counter wraps modulo 2^32 and never sets a pending bit.
- R8: Clock register bit 4 selects the tick: 0 selects `fast_tick_i` and 1 selects `slow_tick_i`. The other tick input is ignored.
- R9: Clock register bit 0 set means the channel advances on every second selected tick. A clear write restarts the halving phase.
- R10: Writing ones to 0x08 clears the matching pending bits and leaves the others alone. A compare hit in the same cycle wins over the acknowledge.
- R11: `irq_o` is high exactly when some pending bit is set together with its enable bit.
- R12: The counter register is read-only: writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| fast_tick_i | input | 1 | Fast reference tick enable |
| slow_tick_i | input | 1 | Slow reference tick enable |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A wrong counter state is visible on the next read of the counter offset. A wrong reload or stop decision is visible on the tick that reaches the compare value: the count reads a remainder other than the tick total modulo the compare value, or it reads past the compare value. A lost or stray pending bit shows at the pending offset and on `irq_o` in the cycle after the hit. A stuck halving phase shifts the divided count by one within two ticks.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_REPEAT  = 2'd1,
    MODE_RSVD    = 2'd2,
    MODE_FREE    = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CLK  = 2'd1,
    REG_CNT  = 2'd2,
    REG_CMP  = 2'd3
  } chan_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_MODE_LSB = 4;
  localparam int CLK_DIV_BIT   = 0;
  localparam int CLK_SRC_BIT   = 4;
endpackage

// File: rtl/cmp_timer_tick_gate.sv
module cmp_timer_tick_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic src_slow_i,
  input  logic div2_i,
  input  logic restart_i,
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  output logic adv_o
);
  logic sel_tick;
  logic phase_q;

  assign sel_tick = src_slow_i ? slow_tick_i : fast_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          phase_q <= 1'b0;
    else if (restart_i)                   phase_q <= 1'b0;
    else if (run_i && sel_tick && div2_i) phase_q <= ~phase_q;
  end

  assign adv_o = run_i && sel_tick && (!div2_i || phase_q);

  // R9: halved rate never advances on two cycles in a row
  a_r9_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && div2_i && !restart_i) |=> (!adv_o || !div2_i));
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_clk_i,
  input  logic              wr_cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] clk_rd_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o
);
  logic             en_q, src_q, div2_q;
  tmr_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_nxt;
  logic             clear_w, adv, hit;

  assign clear_w = wr_ctrl_i && wdata_i[CTRL_CLR_BIT];
  assign cnt_nxt = cnt_q + 1'b1;

  cmp_timer_tick_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (en_q),
    .src_slow_i  (src_q),
    .div2_i      (div2_q),
    .restart_i   (clear_w),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .adv_o       (adv)
  );

  assign hit     = adv && (mode_q == MODE_ONESHOT || mode_q == MODE_REPEAT)
                   && (cnt_nxt == cmp_q);
  assign match_o = hit && !clear_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONESHOT;
    end else if (wr_ctrl_i) begin
      en_q   <= wdata_i[CTRL_EN_BIT];
      mode_q <= tmr_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
    end else if (hit && mode_q == MODE_ONESHOT) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_w)                    cnt_q <= '0;
    else if (hit && mode_q == MODE_REPEAT) cnt_q <= '0;
    else if (adv)                        cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      src_q  <= 1'b0;
      div2_q <= 1'b0;
    end else begin
      if (wr_cmp_i) cmp_q <= wdata_i[CNT_W-1:0];
      if (wr_clk_i) begin
        src_q  <= wdata_i[CLK_SRC_BIT];
        div2_q <= wdata_i[CLK_DIV_BIT];
      end
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_EN_BIT] = en_q;
    ctrl_rd_o[CTRL_MODE_LSB +: 2] = mode_q;
    clk_rd_o = '0;
    clk_rd_o[CLK_SRC_BIT] = src_q;
    clk_rd_o[CLK_DIV_BIT] = div2_q;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_w |=> (cnt_q == '0));
  a_r5_repeat_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && mode_q == MODE_REPEAT && !wr_ctrl_i) |=> (cnt_q == '0));
  a_r6_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && mode_q == MODE_ONESHOT && !wr_ctrl_i) |=> (!en_q && cnt_q == cmp_q));
  a_r3_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clear_w) |=> $stable(cnt_q));
  a_r7_free_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_q == MODE_FREE && !clear_w) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r7_free_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FREE || mode_q == MODE_RSVD) |-> !match_o);
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
  parameter int N_CH = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_ack_i,
  input  logic [N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0] match_i,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] pend_o,
  output logic            irq_o
);
  logic [N_CH-1:0] en_q, pend_q, ack_mask;

  assign ack_mask = wr_ack_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en_i) en_q <= wdata_i;
      pend_q <= (pend_q & ~ack_mask) | match_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(en_q & pend_q);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R10: a hit always lands, even against an acknowledge
    a_r10_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[i] |=> pend_q[i]);
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!match_i[i] && !ack_mask[i]) |=> (pend_q[i] == $past(pend_q[i])));
  end
endmodule

// File: rtl/cmp_timer_bank.sv
module cmp_timer_bank
  import cmp_timer_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  output logic              irq_o
);
  localparam int CH_IDX_W = ADDR_W - 4;

  logic [CH_IDX_W-1:0] ch_idx;
  chan_reg_e           reg_sel;
  logic                aligned, glb_sel;
  logic [N_CH-1:0]     match, irq_en, irq_pend;
  logic [DATA_W-1:0]   ctrl_rd [N_CH];
  logic [DATA_W-1:0]   clk_rd  [N_CH];
  logic [CNT_W-1:0]    cnt_rd  [N_CH];
  logic [CNT_W-1:0]    cmp_rd  [N_CH];

  assign ch_idx  = addr_i[ADDR_W-1:4];
  assign reg_sel = chan_reg_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign glb_sel = aligned && (ch_idx == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel;
    assign sel = we_i && aligned && (ch_idx == CH_IDX_W'(g + 1));

    cmp_timer_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ctrl_i   (sel && reg_sel == REG_CTRL),
      .wr_clk_i    (sel && reg_sel == REG_CLK),
      .wr_cmp_i    (sel && reg_sel == REG_CMP),
      .wdata_i     (wdata_i),
      .fast_tick_i (fast_tick_i),
      .slow_tick_i (slow_tick_i),
      .ctrl_rd_o   (ctrl_rd[g]),
      .clk_rd_o    (clk_rd[g]),
      .cnt_o       (cnt_rd[g]),
      .cmp_o       (cmp_rd[g]),
      .match_o     (match[g])
    );
  end

  cmp_timer_irq #(.N_CH(N_CH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (we_i && glb_sel && reg_sel == REG_CTRL),
    .wr_ack_i (we_i && glb_sel && reg_sel == REG_CNT),
    .wdata_i  (wdata_i[N_CH-1:0]),
    .match_i  (match),
    .en_o     (irq_en),
    .pend_o   (irq_pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (glb_sel) begin
      if (reg_sel == REG_CTRL)     rdata_o = DATA_W'(irq_en);
      else if (reg_sel == REG_CNT) rdata_o = DATA_W'(irq_pend);
    end
    for (int i = 0; i < N_CH; i++) begin
      if (aligned && ch_idx == CH_IDX_W'(i + 1)) begin
        case (reg_sel)
          REG_CTRL: rdata_o = ctrl_rd[i];
          REG_CLK:  rdata_o = clk_rd[i];
          REG_CNT:  rdata_o = DATA_W'(cnt_rd[i]);
          REG_CMP:  rdata_o = DATA_W'(cmp_rd[i]);
        endcase
      end
    end
  end

  // R11: line only rises with a masked-in pending bit in place
  a_r11_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|match) || $past(we_i && glb_sel && reg_sel == REG_CTRL)));
endmodule

// File: tb/cmp_timer_bank_test.sv
`timescale 1ns/1ps
module cmp_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fast_tk = 1'b0;
  logic        slow_tk = 1'b0;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cmp_timer_bank uut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .fast_tick_i (fast_tk),
    .slow_tick_i (slow_tk), .irq_o (irq)
  );

  localparam logic [7:0] A_EN  = 8'h00;
  localparam logic [7:0] A_ACK = 8'h08;

  function automatic logic [7:0] ra(int ch, int r);
    return 8'(16 * ch + 4 * r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic fast(int m);
    @(negedge clk); fast_tk = 1'b1;
    repeat (m) @(negedge clk);
    fast_tk = 1'b0;
  endtask

  task automatic slow(int m);
    @(negedge clk); slow_tk = 1'b1;
    repeat (m) @(negedge clk);
    slow_tk = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ra(1, 0), v); chk("R1 ctrl", v, 0);
    rd(ra(1, 2), v); chk("R1 cnt", v, 0);
    rd(A_EN, v);     chk("R1 en", v, 0);
    rd(A_ACK, v);    chk("R1 pend", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 map
    rd(8'h04, v); chk("R2 hole 0x04", v, 0);
    rd(8'h70, v); chk("R2 hole ch7", v, 0);
    wr(A_EN, 32'h01);
    rd(A_EN, v); chk("R2 enable reg", v, 32'h01);
    wr(ra(6, 3), 32'h55);
    rd(ra(6, 3), v); chk("R2 ch6 compare", v, 32'h55);

    // R5/R3/R11 repeat sweep on channel 1
    for (int c = 1; c <= 6; c++) begin
      for (int m = 0; m <= 13; m++) begin
        wr(ra(1, 3), c);
        wr(A_ACK, 32'h3F);
        wr(ra(1, 0), 32'h13);
        fast(m);
        rd(ra(1, 2), v); chk($sformatf("R5 cnt c=%0d m=%0d", c, m), v, m % c);
        rd(A_ACK, v);    chk($sformatf("R5 pend c=%0d m=%0d", c, m), v, (m >= c) ? 1 : 0);
        chk($sformatf("R11 irq c=%0d m=%0d", c, m), {31'b0, irq}, (m >= c) ? 1 : 0);
      end
    end
    wr(ra(1, 0), 32'h10);

    // R4 clear
    wr(A_ACK, 32'h3F);
    wr(ra(1, 3), 100);
    wr(ra(1, 0), 32'h13);
    fast(9);
    rd(ra(1, 2), v); chk("R4 before clear", v, 9);
    wr(ra(1, 0), 32'h13);
    rd(ra(1, 2), v); chk("R4 cleared", v, 0);
    rd(ra(1, 0), v); chk("R4 clear bit reads 0", v, 32'h11);
    fast(3);
    rd(ra(1, 2), v); chk("R4 restart from zero", v, 3);

    // R3 disabled hold
    wr(ra(1, 0), 32'h10);
    fast(5);
    rd(ra(1, 2), v); chk("R3 disabled hold", v, 3);

    // R6 one-shot on channel 2
    wr(A_ACK, 32'h3F);
    wr(ra(2, 3), 4);
    wr(ra(2, 0), 32'h03);
    fast(7);
    rd(ra(2, 2), v); chk("R6 stop at compare", v, 4);
    rd(ra(2, 0), v); chk("R6 enable cleared", v, 0);
    rd(A_ACK, v);    chk("R6 pending", v, 32'h02);
    chk("R11 masked", {31'b0, irq}, 0);
    wr(A_EN, 32'h02);
    chk("R11 unmasked", {31'b0, irq}, 1);
    wr(A_ACK, 32'h01);
    rd(A_ACK, v); chk("R10 other bit kept", v, 32'h02);
    chk("R10 irq kept", {31'b0, irq}, 1);
    wr(A_ACK, 32'h02);
    rd(A_ACK, v); chk("R10 acked", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);

    // R7 free-run and reserved code
    wr(A_EN, 32'h3F);
    wr(ra(3, 3), 3);
    wr(ra(3, 0), 32'h33);
    fast(10);
    rd(ra(3, 2), v); chk("R7 free count", v, 10);
    rd(A_ACK, v);    chk("R7 no pending", v, 0);
    wr(ra(3, 0), 32'h23);
    fast(4);
    rd(ra(3, 2), v); chk("R7 code2 count", v, 4);
    rd(A_ACK, v);    chk("R7 code2 no pending", v, 0);
    chk("R7 irq low", {31'b0, irq}, 0);
    wr(ra(3, 0), 32'h30);

    // R9 divide-by-two sweep on channel 4
    wr(ra(4, 1), 32'h01);
    rd(ra(4, 1), v); chk("R9 clk reg", v, 32'h01);
    for (int m = 0; m <= 9; m++) begin
      wr(ra(4, 0), 32'h33);
      fast(m);
      rd(ra(4, 2), v); chk($sformatf("R9 half m=%0d", m), v, m / 2);
    end
    wr(ra(4, 0), 32'h30);

    // R8 slow source, R12 counter read-only
    wr(ra(5, 1), 32'h10);
    wr(ra(5, 0), 32'h33);
    fast(5);
    rd(ra(5, 2), v); chk("R8 fast ignored", v, 0);
    slow(3);
    rd(ra(5, 2), v); chk("R8 slow counted", v, 3);
    wr(ra(5, 2), 32'hDEAD);
    rd(ra(5, 2), v); chk("R12 write ignored", v, 3);
    wr(ra(5, 0), 32'h30);

    // R5 two channels side by side
    wr(A_ACK, 32'h3F);
    wr(ra(3, 3), 3);
    wr(ra(3, 0), 32'h13);
    wr(ra(6, 3), 5);
    wr(ra(6, 0), 32'h13);
    fast(11);
    rd(ra(3, 2), v); chk("R5 ch3 count", v, 2);
    rd(ra(6, 2), v); chk("R5 ch6 count", v, 1);
    rd(A_ACK, v);    chk("R5 both pending", v, 32'h24);
    chk("R11 multi irq", {31'b0, irq}, 1);

    finish_run();
  end
endmodule